// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block stores a received byte stream in memory buffers. Each buffer is described by a descriptor in a shared RAM that is 16 bits wide. A descriptor holds a control and status word, a length word and a 32-bit byte pointer to its buffer. The descriptors form a ring. The ring starts at a base word address supplied on an input. Its end is marked only by a wrap flag in the last descriptor, so the block keeps no descriptor count.

Ownership is handed back and forth through an empty flag in each descriptor.

- While the flag is set, the block may fetch the descriptor and fill its buffer.
- When the buffer closes, the block writes back the byte count and the status word with the flag cleared. Three events close a buffer: it fills to the maximum length, the frame ends, or an error strobe arrives.
- The block then moves on to the next descriptor.
- If it fetches a descriptor that the core still holds, it reports busy, throws away bytes until the current frame ends, and then fetches that same descriptor again.

Top module: `rxbd_ring_ctrl`

## Requirements
- R1: After reset, `irq` and `busy` are 0, and the first memory access is a read of word address `ring_base` (the status word).
- R2: A descriptor spans four words. The status word is at +0, the length word at +1, the pointer high half at +2 and the pointer low half at +3. Received bytes are written to the buffer byte address (pointer plus count). An even byte address goes to bits 15:8 of word (address>>1) with `mem_be`=2'b10, and an odd one goes to bits 7:0 with `mem_be`=2'b01.
- R3: Once the byte count reaches `max_len`, the buffer closes. The length word becomes `max_len`, and the status word has the empty flag E (bit 15) at 0 and the last flag L (bit 11) at 0.
- R4: When `rx_end` is sampled, the buffer closes. L (bit 11) is set, E is cleared, and the length word holds the bytes in this buffer, including a byte that arrives in the same cycle.
- R5: The first flag F (bit 10) is set only in the first buffer after reset, after a frame end, after an error close, or after a busy period.
- R6: An error strobe closes the buffer with E cleared and sets its flag. Abort sets bit 3, CRC error sets bit 2 and overrun sets bit 1. A byte that arrives in the same cycle is not stored.
- R7: The write-back keeps the wrap flag W (bit 13), the interrupt flag I (bit 12) and the CM flag (bit 9) as fetched. It writes every other bit that is not a status flag, reserved bits included, as 0.
- R8: After a close, the next fetch reads descriptor address +4, or `ring_base` when W was set.
- R9: `irq` pulses high for exactly one cycle when a buffer whose I flag is set is closed.
- R10: If a fetched descriptor has E=0, `busy` rises and no memory write is made. Bytes are discarded until `rx_end` or an error strobe, after which the same descriptor is fetched again.
- R11: A byte that arrives while a descriptor is being fetched or written back is dropped, and the next buffer to close gets bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_end | input | 1 | Frame end strobe |
| rx_err_ovr | input | 1 | Overrun error strobe |
| rx_err_crc | input | 1 | CRC error strobe |
| rx_err_abort | input | 1 | Abort strobe |
| ring_base | input | AW | Word address of the first descriptor |
| max_len | input | 16 | Maximum bytes per buffer |
| mem_en | output | 1 | RAM access this cycle |
| mem_we | output | 1 | RAM write (else read) |
| mem_be | output | 2 | Byte lane enables, [1] is bits 15:8 |
| mem_addr | output | AW | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, valid one cycle after a read |
| irq | output | 1 | Buffer-closed interrupt pulse |
| busy | output | 1 | Fetched descriptor not owned; discarding |

## Verification
Four input patterns exercise the fill path, and each separates a different close cause.

- **Short frame with the end strobe on its last byte.** This separates a close on frame end from a close on a full buffer, and it checks that the same-cycle byte is counted.
- **Frame longer than `max_len`.** This separates buffers that close full from the final partial buffer, which shows that F, L, the clearing of reserved bits and the wrap to the ring base all work.
- **Ring wraps onto a descriptor still held by the core.** This separates a discarding busy period from normal reception.
- **Error strobe, then a byte during a fetch.** This separates an error close from a normal close, and it separates an overrun caused by a dropped byte from a clean buffer.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

    typedef enum logic [3:0] {
        S_START,
        S_RD_ST,
        S_RD_PH,
        S_RD_PL,
        S_RD_DN,
        S_ARMED,
        S_WB_LEN,
        S_WB_ST,
        S_BUSY
    } rxbd_state_e;

    // Status word bit positions (bit 15 is the most significant)
    localparam int unsigned BIT_E   = 15;
    localparam int unsigned BIT_W   = 13;
    localparam int unsigned BIT_I   = 12;
    localparam int unsigned BIT_L   = 11;
    localparam int unsigned BIT_F   = 10;
    localparam int unsigned BIT_CM  = 9;
    localparam int unsigned BIT_AB  = 3;
    localparam int unsigned BIT_CR  = 2;
    localparam int unsigned BIT_OV  = 1;

    localparam int unsigned OFS_STAT = 0;
    localparam int unsigned OFS_LEN  = 1;
    localparam int unsigned OFS_PH   = 2;
    localparam int unsigned OFS_PL   = 3;
    localparam int unsigned DESC_WORDS = 4;

endpackage

// File: rtl/rxbd_byte_lane.sv
module rxbd_byte_lane #(
    parameter int unsigned AW = 10,
    localparam int unsigned PW = AW + 1
) (
    input  logic [PW-1:0] byte_addr,
    input  logic [7:0]    din,
    output logic [AW-1:0] word_addr,
    output logic [1:0]    be,
    output logic [15:0]   wdata
);
    // Even byte address lands in the upper lane
    always_comb begin
        word_addr = byte_addr[PW-1:1];
        be        = byte_addr[0] ? 2'b01 : 2'b10;
        wdata     = {din, din};
    end
endmodule

// File: rtl/rxbd_status_fmt.sv
module rxbd_status_fmt
    import rxbd_pkg::*;
(
    input  logic        keep_w,
    input  logic        keep_i,
    input  logic        keep_cm,
    input  logic        last,
    input  logic        first,
    input  logic        err_ab,
    input  logic        err_cr,
    input  logic        err_ov,
    output logic [15:0] word
);
    always_comb begin
        word          = '0;
        word[BIT_W]   = keep_w;
        word[BIT_I]   = keep_i;
        word[BIT_CM]  = keep_cm;
        word[BIT_L]   = last;
        word[BIT_F]   = first;
        word[BIT_AB]  = err_ab;
        word[BIT_CR]  = err_cr;
        word[BIT_OV]  = err_ov;
    end
endmodule

// File: rtl/rxbd_ring_ctrl.sv
module rxbd_ring_ctrl
    import rxbd_pkg::*;
#(
    parameter int unsigned AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_end,
    input  logic          rx_err_ovr,
    input  logic          rx_err_crc,
    input  logic          rx_err_abort,
    input  logic [AW-1:0] ring_base,
    input  logic [15:0]   max_len,
    output logic          mem_en,
    output logic          mem_we,
    output logic [1:0]    mem_be,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    output logic          irq,
    output logic          busy
);
    localparam int unsigned PW = AW + 1;

    typedef struct packed {
        rxbd_state_e    st;
        logic [AW-1:0]  cur;
        logic [15:0]    ptr_hi;
        logic [PW-1:0]  ptr;
        logic [15:0]    cnt;
        logic           w;
        logic           i;
        logic           cm;
        logic           lf;
        logic           ab;
        logic           cr;
        logic           ov;
        logic           first;
        logic           ovr;
        logic           irq;
    } ctrl_t;

    ctrl_t q, d;

    logic [PW-1:0] byte_addr;
    logic [AW-1:0] lane_addr;
    logic [1:0]    lane_be;
    logic [15:0]   lane_data;
    logic [15:0]   stat_word;
    logic [15:0]   cnt_inc;
    logic          err_any;

    assign byte_addr = q.ptr + PW'(q.cnt);
    assign cnt_inc   = q.cnt + 16'd1;
    assign err_any   = rx_err_ovr | rx_err_crc | rx_err_abort;

    rxbd_byte_lane #(.AW(AW)) i_lane (
        .byte_addr (byte_addr),
        .din       (rx_data),
        .word_addr (lane_addr),
        .be        (lane_be),
        .wdata     (lane_data)
    );

    rxbd_status_fmt i_fmt (
        .keep_w  (q.w),
        .keep_i  (q.i),
        .keep_cm (q.cm),
        .last    (q.lf),
        .first   (q.first),
        .err_ab  (q.ab),
        .err_cr  (q.cr),
        .err_ov  (q.ov | q.ovr),
        .word    (stat_word)
    );

    always_comb begin
        d         = q;
        d.irq     = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_be    = 2'b11;
        mem_addr  = q.cur;
        mem_wdata = '0;
        unique case (q.st)
            S_START: begin
                d.cur = ring_base;
                d.st  = S_RD_ST;
            end
            S_RD_ST: begin
                mem_en   = 1'b1;
                mem_addr = q.cur + AW'(OFS_STAT);
                d.st     = S_RD_PH;
            end
            S_RD_PH: begin
                mem_en   = 1'b1;
                mem_addr = q.cur + AW'(OFS_PH);
                d.w      = mem_rdata[BIT_W];
                d.i      = mem_rdata[BIT_I];
                d.cm     = mem_rdata[BIT_CM];
                d.st     = mem_rdata[BIT_E] ? S_RD_PL : S_BUSY;
            end
            S_RD_PL: begin
                mem_en   = 1'b1;
                mem_addr = q.cur + AW'(OFS_PL);
                d.ptr_hi = mem_rdata;
                d.st     = S_RD_DN;
            end
            S_RD_DN: begin
                d.ptr = PW'({q.ptr_hi, mem_rdata});
                d.cnt = '0;
                d.lf  = 1'b0;
                d.ab  = 1'b0;
                d.cr  = 1'b0;
                d.ov  = 1'b0;
                d.st  = S_ARMED;
            end
            S_ARMED: begin
                if (err_any) begin
                    d.ab = rx_err_abort;
                    d.cr = rx_err_crc;
                    d.ov = rx_err_ovr;
                    d.st = S_WB_LEN;
                end else begin
                    if (rx_valid) begin
                        mem_en    = 1'b1;
                        mem_we    = 1'b1;
                        mem_addr  = lane_addr;
                        mem_be    = lane_be;
                        mem_wdata = lane_data;
                        d.cnt     = cnt_inc;
                        if (cnt_inc >= max_len) begin
                            d.st = S_WB_LEN;
                        end
                    end
                    if (rx_end) begin
                        d.lf = 1'b1;
                        d.st = S_WB_LEN;
                    end
                end
            end
            S_WB_LEN: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.cur + AW'(OFS_LEN);
                mem_wdata = q.cnt;
                d.st      = S_WB_ST;
            end
            S_WB_ST: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.cur + AW'(OFS_STAT);
                mem_wdata = stat_word;
                d.irq     = q.i;
                d.ovr     = 1'b0;
                d.first   = q.lf | q.ab | q.cr | q.ov;
                d.cur     = q.w ? ring_base : q.cur + AW'(DESC_WORDS);
                d.st      = S_RD_ST;
            end
            S_BUSY: begin
                if (rx_end || err_any) begin
                    d.first = 1'b1;
                    d.st    = S_RD_ST;
                end
            end
            default: d.st = S_START;
        endcase
        // Bytes arriving outside the fill and discard states are lost
        if (rx_valid && q.st != S_ARMED && q.st != S_BUSY) begin
            d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_START;
            q.first <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign irq  = q.irq;
    assign busy = (q.st == S_BUSY);

    AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_we); // R10

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R9

    AST_WB_OWNER_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WB_ST) |-> (mem_we && !mem_wdata[BIT_E] && mem_wdata[14] == 1'b0)); // R7

    AST_NEXT_DESC: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RD_ST && $past(q.st) == S_WB_ST) |->
        (mem_addr == ring_base || mem_addr == $past(q.cur) + AW'(DESC_WORDS))); // R8

    AST_FILL_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_ARMED && mem_we) |-> $onehot(mem_be)); // R2

endmodule

// File: tb/test_rxbd_ring_ctrl.sv
`timescale 1ns/1ps
module test_rxbd_ring_ctrl;
    localparam int unsigned AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_end = 1'b0;
    logic          rx_err_ovr = 1'b0;
    logic          rx_err_crc = 1'b0;
    logic          rx_err_abort = 1'b0;
    logic [AW-1:0] ring_base = AW'(16);
    logic [15:0]   max_len = 16'd4;
    logic          mem_en, mem_we;
    logic [1:0]    mem_be;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata;
    logic          irq, busy;

    logic [15:0] mem [0:(1<<AW)-1];
    int n_chk = 0;
    int n_fail = 0;
    int irq_cnt = 0;
    int wr_cnt = 0;
    logic        seen_first = 1'b0;
    logic [AW-1:0] first_addr = '0;
    logic        first_we = 1'b0;

    always #2 clk = ~clk;

    rxbd_ring_ctrl #(.AW(AW)) i_rxbd_ring_ctrl (
        .clk, .rst_n, .rx_valid, .rx_data, .rx_end, .rx_err_ovr, .rx_err_crc,
        .rx_err_abort, .ring_base, .max_len, .mem_en, .mem_we, .mem_be,
        .mem_addr, .mem_wdata, .mem_rdata, .irq, .busy
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                if (mem_be[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
                if (mem_be[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
            end
            mem_rdata <= mem[mem_addr];
        end
        if (rst_n && irq) irq_cnt <= irq_cnt + 1;
        if (rst_n && mem_en && mem_we) wr_cnt <= wr_cnt + 1;
        if (rst_n && mem_en && !seen_first) begin
            seen_first <= 1'b1;
            first_addr <= mem_addr;
            first_we   <= mem_we;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic v, input logic e);
        @(negedge clk);
        rx_valid = v; rx_data = b; rx_end = e;
        @(negedge clk);
        rx_valid = 1'b0; rx_end = 1'b0;
        idle(10);
    endtask

    task automatic t_reset;
        idle(12);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 first read addr", 32'(first_addr), 32'd16);
        check("R1 first access is read", 32'(first_we), 32'd0);
    endtask

    // D0: 3-byte frame, end on last byte
    task automatic t_short_frame;
        send(8'hAA, 1'b1, 1'b0);
        send(8'hBB, 1'b1, 1'b0);
        send(8'hCC, 1'b1, 1'b1);
        check("R2 bytes word0", 32'(mem[256]), 32'h0000AABB);
        check("R2 odd lane untouched", 32'(mem[257]), 32'h0000CC00);
        check("R4 length", 32'(mem[17]), 32'd3);
        check("R4 R5 R7 status I|L|F", 32'(mem[16]), 32'h00001C00);
        check("R9 irq pulse", 32'(irq_cnt), 32'd1);
    endtask

    // D1 fills to max_len, D2 takes the rest and wraps
    task automatic t_long_frame;
        send(8'h11, 1'b1, 1'b0);
        send(8'h22, 1'b1, 1'b0);
        send(8'h33, 1'b1, 1'b0);
        send(8'h44, 1'b1, 1'b0);
        check("R3 full length", 32'(mem[21]), 32'd4);
        check("R3 R5 R7 full status CM|F", 32'(mem[20]), 32'h00000600);
        check("R2 data", {mem[288], mem[289]}, 32'h11223344);
        send(8'h55, 1'b1, 1'b0);
        send(8'h66, 1'b1, 1'b0);
        send(8'h00, 1'b0, 1'b1);
        check("R4 R5 tail status W|L", 32'(mem[24]), 32'h00002800);
        check("R4 tail length", 32'(mem[25]), 32'd2);
        check("R9 no irq without I", 32'(irq_cnt), 32'd1);
    endtask

    // Wrap lands on D0 still held by core (R8, R10)
    task automatic t_busy;
        int w0;
        check("R8 R10 busy after wrap", 32'(busy), 32'd1);
        w0 = wr_cnt;
        send(8'hEE, 1'b1, 1'b0);
        send(8'hEF, 1'b1, 1'b0);
        check("R10 no writes while busy", 32'(wr_cnt), 32'(w0));
        mem[16] = 16'h8000;
        send(8'h00, 1'b0, 1'b1);
        check("R10 busy clears after refetch", 32'(busy), 32'd0);
    endtask

    // Error close on D0, then overrun during fetch of D1
    task automatic t_errors;
        send(8'h77, 1'b1, 1'b0);
        @(negedge clk);
        rx_err_crc = 1'b1;
        @(negedge clk);
        rx_err_crc = 1'b0;
        idle(10);
        check("R6 crc status CR|F", 32'(mem[16]), 32'h00000404);
        check("R6 error length", 32'(mem[17]), 32'd1);
        check("R2 reused buffer", 32'(mem[256]), 32'h000077BB);
        check("R10 busy on D1", 32'(busy), 32'd1);
        mem[20] = 16'h8000;
        @(negedge clk);
        rx_end = 1'b1;
        @(negedge clk);
        rx_end = 1'b0;
        rx_valid = 1'b1; rx_data = 8'h99;
        @(negedge clk);
        rx_valid = 1'b0;
        idle(10);
        send(8'h88, 1'b1, 1'b1);
        check("R11 overrun status OV|L|F", 32'(mem[20]), 32'h00000C02);
        check("R11 length", 32'(mem[21]), 32'd1);
        check("R11 dropped byte absent", 32'(mem[288]), 32'h00008822);
        check("R9 irq count", 32'(irq_cnt), 32'd1);
    endtask

    initial begin
        for (int a = 0; a < (1 << AW); a++) mem[a] = '0;
        mem[16] = 16'h9000; mem[18] = 16'h0000; mem[19] = 16'h0200;
        mem[20] = 16'hC210; mem[22] = 16'h0000; mem[23] = 16'h0240;
        mem[24] = 16'hA000; mem[26] = 16'h0000; mem[27] = 16'h0280;
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_short_frame();
        t_long_frame();
        t_busy();
        t_errors();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule